// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a byte-addressed serial nonvolatile memory reached over a four-wire SPI link in mode 0. The SPI clock and select are brought into the system clock domain and their edges are found there. Each select frame starts with an 8-bit command byte, most significant bit first. The memory commands follow it with a 16-bit address. Reads stream bytes out one after another. Writes collect up to one page of bytes and start a timed internal programming cycle when the select line rises on a clean byte boundary.

The storage is an on-chip register file whose size is a parameter. Programming is modelled as a counter that keeps a busy flag set for a fixed number of system clocks. A nearby protection and status unit controls three things: it can veto array commits, it can veto status writes, and it supplies the upper six bits of the status byte. It also receives every accepted status write as a one-cycle pulse.

Top module: `spi_eeprom_engine`

## Requirements
- R1: Command bytes: 0x03 array read, 0x02 array write, 0x06 set write latch, 0x04 clear write latch, 0x05 status read, 0x01 status write. Any other byte makes the rest of the frame have no effect: no output enable and no latch change.
- R2: A read or write command is followed by a 16-bit address. Only its low ADDR_W bits select a byte and the upper bits are ignored.
- R3: Data and address bits are sampled on rising SPI clock edges. Output bits go out most significant bit first, and spi_miso changes only after falling SPI clock edges.
- R4: A read returns the byte at the pointer and then increments the pointer. After the last byte of the array the pointer wraps to address 0, and the read continues while the frame lasts.
- R5: Write data goes into a page buffer of 2^PAGE_W bytes. Each byte advances only the low PAGE_W pointer bits, which wrap inside the page, so later bytes overwrite earlier ones.
- R6: An array write commits only when select rises with the bit count at a byte boundary and at least one data byte received. Any other ending abandons it, and then the busy flag stays clear and the write latch is kept.
- R7: The write latch is set by 0x06 and cleared by 0x04, in each case only when select rises exactly 8 bits into the frame. An array or status write without the latch has no effect. An accepted array or status write clears the latch.
- R8: After a commit the busy flag is 1 for exactly WR_CYCLES system clocks. While busy, read, write and latch commands are ignored, but status read still works.
- R9: spi_miso_oe is 0 whenever select is high and while no read or status byte is being shifted out.
- R10: After reset, select must be seen high and then low before a frame is accepted. A frame with select already low at reset is ignored.
- R11: The status byte is {stat_ext_i[5:0], write latch, busy} with busy in bit 0. A status write of exactly one data byte, with the latch set and stat_lock_i low, pulses stat_wr_o once with the byte on stat_wdata_o and starts a programming cycle.
- R12: While array_lock_i is 1 at the end of a write frame, the array and the busy flag are left unchanged.
- R13: A commit changes only the buffered bytes of the addressed page. Every other byte of the array keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the SPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk | input | 1 | SPI serial clock, mode 0 |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 means high-impedance) |
| array_lock_i | input | 1 | Veto for array commits from the protection unit |
| stat_lock_i | input | 1 | Veto for status writes from the protection unit |
| stat_ext_i | input | 6 | Upper six bits of the status byte |
| stat_wr_o | output | 1 | One-cycle pulse for an accepted status write |
| stat_wdata_o | output | 8 | Byte carried by the status write |

## Verification
The main read/write path is exercised with three kinds of traffic. The first fills every page with an address-dependent pattern while the ignored address bits hold junk. The second is one read that runs past the top of the array, which separates a wrapping pointer from one that stops or saturates. The third is a pair of writes that start near a page end or overrun the page, which shows whether the wrap is confined to the page and whether neighbouring bytes survive. Frames that end on a partial byte, one bit late, or without data are set against well-formed ones to pin down exactly when a commit happens. Busy-time traffic and the two lock inputs separate ignored commands from the status read, which must still answer.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam logic [7:0] CMD_READ    = 8'h03;
    localparam logic [7:0] CMD_WRITE   = 8'h02;
    localparam logic [7:0] CMD_ARM     = 8'h06;
    localparam logic [7:0] CMD_DISARM  = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;

    typedef enum logic [3:0] {
        PH_CMD,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_WDATA,
        PH_RDATA,
        PH_SDATA,
        PH_SIN,
        PH_SEND,
        PH_CEND,
        PH_SKIP
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_ARM,
        OP_DISARM
    } op_e;

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign lvl_o = st_q[STAGES-1];
endmodule

// File: rtl/eeprom_edge_det.sv
module eeprom_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // busy-length observer used only by the checks below
    logic [CW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_q == (CW+1)'(CYCLES));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R8
    busy_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]   page_i,
    input  logic [(8<<PAGE_W)-1:0]     data_i,
    input  logic [(1<<PAGE_W)-1:0]     mask_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [7:0]                 rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PB    = 1 << PAGE_W;
    localparam int PGW   = ADDR_W - PAGE_W;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [PGW-1:0] PG = PGW'(g >> PAGE_W);
        localparam int             SL = g % PB;
        logic [7:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (commit_i && page_i == PG && mask_i[SL]) cell_d = data_i[SL*8 +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign cells[g] = cell_q;
    end

    assign rd_data_o = cells[rd_addr_i];

    // R13
    array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!commit_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_clk,
    input  logic       spi_sel_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic       array_lock_i,
    input  logic       stat_lock_i,
    input  logic [5:0] stat_ext_i,
    output logic       stat_wr_o,
    output logic [7:0] stat_wdata_o
);
    localparam int PB  = 1 << PAGE_W;
    localparam int PGW = ADDR_W - PAGE_W;

    typedef struct packed {
        logic              active;
        phase_e            phase;
        op_e               op;
        logic [2:0]        bitcnt;
        logic [6:0]        shin;
        logic [ADDR_W-1:0] ptr;
        logic              got_data;
        logic [7:0]        outsh;
        logic              so;
        logic              oe;
        logic              wel;
        logic [7:0]        sts_new;
        logic [PB*8-1:0]   pbuf;
        logic [PB-1:0]     pmask;
        logic              commit;
        logic              sts_wr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [2:0] lvl;
    logic [1:0] rise, fall;
    logic       sck_rise, sck_fall, sel_rise, sel_fall, mosi_s;
    logic       busy;
    logic [7:0] rd_data;

    eeprom_pin_sync #(.W(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({spi_mosi, spi_sel_n, spi_clk}),
        .lvl_o  (lvl)
    );

    eeprom_edge_det #(.W(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl[1:0]),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign sck_rise = rise[0];
    assign sck_fall = fall[0];
    assign sel_rise = rise[1];
    assign sel_fall = fall[1];
    assign mosi_s   = lvl[2];

    eeprom_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (c_q.commit | c_q.sts_wr),
        .busy_o  (busy)
    );

    eeprom_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (c_q.commit),
        .page_i    (c_q.ptr[ADDR_W-1:PAGE_W]),
        .data_i    (c_q.pbuf),
        .mask_i    (c_q.pmask),
        .rd_addr_i (c_q.ptr),
        .rd_data_o (rd_data)
    );

    logic [7:0]        rx_byte, status, tx;
    logic              byte_done;
    logic [PAGE_W-1:0] slot;

    always_comb begin
        c_d       = c_q;
        c_d.commit = 1'b0;
        c_d.sts_wr = 1'b0;
        rx_byte   = {c_q.shin, mosi_s};
        byte_done = (c_q.bitcnt == 3'd7);
        slot      = c_q.ptr[PAGE_W-1:0];
        status    = {stat_ext_i, c_q.wel, busy};
        tx        = (c_q.phase == PH_RDATA) ? rd_data : status;

        if (sel_fall) begin
            c_d.active   = 1'b1;
            c_d.phase    = PH_CMD;
            c_d.op       = OP_NONE;
            c_d.bitcnt   = '0;
            c_d.got_data = 1'b0;
            c_d.oe       = 1'b0;
        end else if (sel_rise) begin
            c_d.active = 1'b0;
            c_d.oe     = 1'b0;
            c_d.phase  = PH_CMD;
            c_d.bitcnt = '0;
            if (c_q.active && c_q.bitcnt == 3'd0) begin
                case (c_q.phase)
                    PH_CEND: c_d.wel = (c_q.op == OP_ARM);
                    PH_WDATA: begin
                        if (c_q.got_data && c_q.wel && !array_lock_i && !busy) begin
                            c_d.commit = 1'b1;
                            c_d.wel    = 1'b0;
                        end
                    end
                    PH_SEND: begin
                        if (c_q.wel && !stat_lock_i && !busy) begin
                            c_d.sts_wr = 1'b1;
                            c_d.wel    = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (c_q.active && sck_rise) begin
            c_d.bitcnt = c_q.bitcnt + 3'd1;
            c_d.shin   = rx_byte[6:0];
            case (c_q.phase)
                PH_CMD: begin
                    if (byte_done) begin
                        case (rx_byte)
                            CMD_READ: begin
                                c_d.op    = OP_READ;
                                c_d.phase = busy ? PH_SKIP : PH_ADDR_HI;
                            end
                            CMD_WRITE: begin
                                c_d.op    = OP_WRITE;
                                c_d.phase = busy ? PH_SKIP : PH_ADDR_HI;
                            end
                            CMD_ARM: begin
                                c_d.op    = OP_ARM;
                                c_d.phase = busy ? PH_SKIP : PH_CEND;
                            end
                            CMD_DISARM: begin
                                c_d.op    = OP_DISARM;
                                c_d.phase = busy ? PH_SKIP : PH_CEND;
                            end
                            CMD_STAT_RD: c_d.phase = PH_SDATA;
                            CMD_STAT_WR: c_d.phase = busy ? PH_SKIP : PH_SIN;
                            default:     c_d.phase = PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR_HI: begin
                    c_d.ptr = {c_q.ptr[ADDR_W-2:0], mosi_s};
                    if (byte_done) c_d.phase = PH_ADDR_LO;
                end
                PH_ADDR_LO: begin
                    c_d.ptr = {c_q.ptr[ADDR_W-2:0], mosi_s};
                    if (byte_done) begin
                        c_d.phase    = (c_q.op == OP_READ) ? PH_RDATA : PH_WDATA;
                        c_d.pmask    = '0;
                        c_d.got_data = 1'b0;
                    end
                end
                PH_WDATA: begin
                    if (byte_done) begin
                        c_d.pbuf[{slot, 3'b000} +: 8] = rx_byte;
                        c_d.pmask[slot]               = 1'b1;
                        c_d.ptr[PAGE_W-1:0]           = slot + 1'b1;
                        c_d.got_data                  = 1'b1;
                    end
                end
                PH_SIN: begin
                    if (byte_done) begin
                        c_d.sts_new = rx_byte;
                        c_d.phase   = PH_SEND;
                    end
                end
                PH_CEND, PH_SEND: c_d.phase = PH_SKIP;
                default: ;
            endcase
        end else if (c_q.active && sck_fall) begin
            if (c_q.phase == PH_RDATA || c_q.phase == PH_SDATA) begin
                if (c_q.bitcnt == 3'd0) begin
                    c_d.outsh = tx;
                    c_d.so    = tx[7];
                    c_d.oe    = 1'b1;
                    if (c_q.phase == PH_RDATA) c_d.ptr = c_q.ptr + 1'b1;
                end else begin
                    c_d.so = c_q.outsh[3'd7 - c_q.bitcnt];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign spi_miso     = c_q.so;
    assign spi_miso_oe  = c_q.oe;
    assign stat_wr_o    = c_q.sts_wr;
    assign stat_wdata_o = c_q.sts_new;

    // R6
    commit_at_sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.commit || c_q.sts_wr) |-> $past(sel_rise));

    // R7
    commit_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.commit || c_q.sts_wr) |-> $past(c_q.wel));

    // R8
    no_commit_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(c_q.commit || c_q.sts_wr));

    // R9
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> !spi_miso_oe);

    // R1
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_SKIP) |-> !spi_miso_oe);

    // R3
    miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> $past(sck_fall));
endmodule

// File: tb/spi_eeprom_engine_bench.sv
module spi_eeprom_engine_bench;
    localparam int AW   = 8;
    localparam int PW   = 5;
    localparam int WRC  = 1500;
    localparam int HALF = 6;
    localparam logic [5:0] EXT = 6'b101101;
    localparam logic [7:0] ST_IDLE = {EXT, 2'b00};
    localparam logic [7:0] ST_WEL  = {EXT, 2'b10};
    localparam logic [7:0] ST_BUSY = {EXT, 2'b01};

    logic clk = 0, rst_n = 0;
    logic sck = 0, sel_n = 0, mosi = 0;
    logic miso, miso_oe, array_lock = 0, stat_lock = 0, stat_wr;
    logic [7:0] stat_wdata;

    int checks = 0, errors = 0, oe_cnt = 0, sts_cnt = 0;
    logic [7:0] sts_last = 0;
    logic [7:0] model [256];

    always #2 clk = ~clk;

    spi_eeprom_engine #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) u_spi_eeprom_engine (
        .clk(clk), .rst_n(rst_n), .spi_clk(sck), .spi_sel_n(sel_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .array_lock_i(array_lock),
        .stat_lock_i(stat_lock), .stat_ext_i(EXT), .stat_wr_o(stat_wr),
        .stat_wdata_o(stat_wdata)
    );

    always @(posedge clk) begin
        if (miso_oe) oe_cnt <= oe_cnt + 1;
        if (rst_n && stat_wr) begin
            sts_cnt  <= sts_cnt + 1;
            sts_last <= stat_wdata;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_n(HALF);
            rx[i] = miso;
            sck = 1;
            wait_n(HALF);
            sck = 0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic sel();
        sel_n = 0;
        wait_n(HALF);
    endtask

    task automatic desel();
        wait_n(HALF);
        sel_n = 1;
        wait_n(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] c);
        logic [7:0] r;
        sel(); xfer(c, r); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h01;
        for (int i = 0; i < 60 && s[0]; i++) rdsr(s);
        chk("R8 busy clears", {15'd0, s[0]}, 16'd0);
    endtask

    task automatic wr_frame(input logic [15:0] a, input int n, input logic [7:0] base);
        logic [7:0] r;
        sel(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
        for (int k = 0; k < n; k++) xfer(base + 8'(k), r);
        desel();
    endtask

    task automatic rd_check(input logic [15:0] a, input int n, input string tag);
        logic [7:0] r;
        sel(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            chk(tag, {8'd0, r}, {8'd0, model[8'(a[7:0] + 8'(k))]});
        end
        desel();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, r;
        int oe0, sc0;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wait_n(10);
        rst_n = 1;
        wait_n(4);
        chk("R9 reset oe", {15'd0, miso_oe}, 16'd0);

        // R10: select already low at reset, frame must be ignored
        oe0 = oe_cnt;
        xfer(8'h05, r); xfer(8'h00, r);
        chk("R10 no frame without select edge", 16'(oe_cnt - oe0), 16'd0);
        sel_n = 1; wait_n(2 * HALF);

        // R11 status layout, R7 latch clear at start
        rdsr(s); chk("R11 status idle", {8'd0, s}, {8'd0, ST_IDLE});

        // R7 write without latch has no effect
        wr_frame(16'h0000, 4, 8'hAA);
        rdsr(s); chk("R7 no commit without latch", {8'd0, s}, {8'd0, ST_IDLE});
        rd_check(16'h0000, 4, "R7 array untouched");

        // R7 set and clear latch, exact 8 bits required
        cmd1(8'h06); rdsr(s); chk("R7 latch set", {8'd0, s}, {8'd0, ST_WEL});
        cmd1(8'h04); rdsr(s); chk("R7 latch clear", {8'd0, s}, {8'd0, ST_IDLE});
        sel(); xfer(8'h06, r); bits(8'h00, 1, r); desel();
        rdsr(s); chk("R7 nine-bit set ignored", {8'd0, s}, {8'd0, ST_IDLE});

        // fill the array page by page, junk in upper address bits (R2)
        for (int p = 0; p < 8; p++) begin
            logic [7:0] rr;
            cmd1(8'h06);
            sel(); xfer(8'h02, rr); xfer(8'hE0 | 8'(p), rr); xfer(8'(p * 32), rr);
            for (int k = 0; k < 32; k++) begin
                logic [7:0] v;
                v = 8'(p * 32 + k) * 8'd7 + 8'h13;
                xfer(v, rr);
                model[p * 32 + k] = v;
            end
            desel();
            rdsr(s); chk("R8 busy after commit, R7 latch cleared", {8'd0, s}, {8'd0, ST_BUSY});
            wait_idle();
        end

        // R4 wrap over array top, R3 MSB-first stream, R2 ignored address bits
        rd_check(16'h5AF0, 272, "R4 R3 R2 sequential read");

        // R5 in-page wrap from slot 30
        cmd1(8'h06); wr_frame(16'h003E, 4, 8'hC0); wait_idle();
        model[8'h3E] = 8'hC0; model[8'h3F] = 8'hC1; model[8'h20] = 8'hC2; model[8'h21] = 8'hC3;
        rd_check(16'h0020, 32, "R5 R13 page wrap");
        // R5 overrun: 34 bytes into one page
        cmd1(8'h06); wr_frame(16'h0040, 34, 8'h50); wait_idle();
        for (int k = 0; k < 34; k++) model[8'h40 + (k % 32)] = 8'h50 + 8'(k);
        rd_check(16'h0020, 96, "R5 R13 overrun");

        // R6 partial byte abandons
        cmd1(8'h06);
        sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h80, r); xfer(8'h99, r); bits(8'hFF, 3, r); desel();
        rdsr(s); chk("R6 partial byte abandons", {8'd0, s}, {8'd0, ST_WEL});
        sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h81, r); desel();
        rdsr(s); chk("R6 no data abandons", {8'd0, s}, {8'd0, ST_WEL});
        rd_check(16'h0080, 2, "R6 array untouched");
        cmd1(8'h04);

        // R8 commands ignored while busy, status read works
        cmd1(8'h06); wr_frame(16'h0090, 1, 8'h3C); model[8'h90] = 8'h3C;
        oe0 = oe_cnt;
        sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h90, r); xfer(8'h00, r); desel();
        chk("R8 read ignored while busy", 16'(oe_cnt - oe0), 16'd0);
        cmd1(8'h06);
        rdsr(s); chk("R8 status read while busy", {8'd0, s}, {8'd0, ST_BUSY});
        wait_idle();
        rdsr(s); chk("R8 latch set ignored while busy", {8'd0, s}, {8'd0, ST_IDLE});
        rd_check(16'h0090, 1, "R8 committed byte");

        // R12 array lock vetoes the commit
        cmd1(8'h06); array_lock = 1;
        wr_frame(16'h00A0, 1, 8'h77);
        array_lock = 0;
        rdsr(s); chk("R12 locked write no busy", {8'd0, s}, {8'd0, ST_WEL});
        rd_check(16'h00A0, 1, "R12 locked byte unchanged");
        cmd1(8'h04);

        // R11 status write
        sc0 = sts_cnt;
        cmd1(8'h06);
        sel(); xfer(8'h01, r); xfer(8'h8C, r); desel();
        chk("R11 status pulse", 16'(sts_cnt - sc0), 16'd1);
        chk("R11 status data", {8'd0, sts_last}, 16'h008C);
        rdsr(s); chk("R11 status write busy", {8'd0, s}, {8'd0, ST_BUSY});
        wait_idle();
        cmd1(8'h06); stat_lock = 1;
        sel(); xfer(8'h01, r); xfer(8'h33, r); desel();
        stat_lock = 0;
        sel(); xfer(8'h01, r); xfer(8'h44, r); bits(8'h00, 1, r); desel();
        chk("R11 locked or long status write", 16'(sts_cnt - sc0), 16'd1);
        rdsr(s); chk("R11 latch kept", {8'd0, s}, {8'd0, ST_WEL});

        // R1 unknown command: no output, latch unaffected
        oe0 = oe_cnt;
        sel(); xfer(8'hFF, r); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); desel();
        cmd1(8'h07);
        chk("R1 unknown command quiet", 16'(oe_cnt - oe0), 16'd0);
        rdsr(s); chk("R1 latch unaffected", {8'd0, s}, {8'd0, ST_WEL});
        chk("R9 oe after frames", {15'd0, miso_oe}, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule